// File: doc/BRIEF.md
# Sense-Reversing Centralized Barrier

This unit synchronizes a fixed group of agents, such as cores or hardware threads. Each agent raises a one-cycle arrive strobe when it reaches a synchronization point. It then waits until every member of the group has arrived in the same episode. The unit keeps one shared arrival counter and one global release flag. Each agent also holds a private sense bit, which it inverts each time it arrives. An agent is released once the global flag equals its sense bit.

When the final arrival of an episode is counted, the counter goes back to zero and the flag inverts, both on the same clock edge. Every waiting agent then sees a release pulse in the next cycle. Sense alternates from one episode to the next, so the next episode can begin at once. An agent may arrive again in the very cycle it is released, without a separate drain phase.

Several agents may arrive in the same cycle, and all of them are counted. An agent that strobes again while it is still waiting is ignored, and a sticky error flag is set.

Top module: `sense_barrier`

## Requirements
- R1: No agent receives a release pulse until all NUM_AGENTS agents have arrived in the current episode. The release pulses of all agents appear together in the cycle that follows the clock edge at which the final arrival was sampled.
- R2: Arrivals from any number of agents in the same cycle are all counted in that cycle, including all agents arriving at once.
- R3: Completion returns the arrival counter to zero. An agent that arrives during its own release cycle is accepted and counts toward the next episode, starting from zero.
- R4: `flagOut` inverts on each completed episode and is otherwise stable. Each accepted arrival inverts the agent's sense bit, and an agent is released when its sense bit equals the flag.
- R5: An arrive strobe from an agent that is waiting and not in its release cycle adds nothing to the count. The same strobe sets `errorOut`, which stays at 1 until reset.
- R6: After reset, `flagOut`, `errorOut`, `waitingOut` and `releaseOut` are all 0, and the arrival counter and every sense bit are 0.
- R7: `releaseOut[i]` is high for exactly one cycle per release. `waitingOut[i]` is high from the cycle after an accepted arrival up to and including the release cycle, and is low after that unless the agent arrived again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| arriveIn | input | NUM_AGENTS | Per-agent arrive strobe, bit i for agent i |
| releaseOut | output | NUM_AGENTS | Per-agent single-cycle release pulse |
| waitingOut | output | NUM_AGENTS | Per-agent level, high while the agent is held at the barrier |
| flagOut | output | 1 | Global release flag; inverts on each completed episode |
| errorOut | output | 1 | Sticky flag for an arrive strobe while already waiting |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a release and a fresh arrival. The bench drives arrive strobes for two agents in the exact cycle in which their release pulses are visible. It then completes the next episode with the remaining two agents only. Release in that final step shows that the early arrivals were counted from zero, and an unchanged `errorOut` shows they were not taken as duplicates.

The second pair is a duplicate strobe and legitimate arrivals. The bench repeats one agent's strobe and then brings in all but one of the others. It judges the outcome by the absence of a premature release and by the error flag latching and staying set.

// File: rtl/barrier_pkg.sv
package barrier_pkg;
  // Width of the per-cycle arrival increment carried from control to datapath.
  localparam int STROBE_CNT_W = 8;

  typedef struct packed {
    logic                    addEn;
    logic [STROBE_CNT_W-1:0] addCount;
  } barStrobe_t;
endpackage

// File: rtl/barrier_ctrl.sv
module barrier_ctrl
  import barrier_pkg::*;
#(
  parameter int NUM_AGENTS = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_AGENTS-1:0] arriveIn,
  input  logic                  flagQ,
  output logic [NUM_AGENTS-1:0] releaseOut,
  output logic [NUM_AGENTS-1:0] waitingOut,
  output logic                  errorOut,
  output barStrobe_t            strobe
);

  logic [NUM_AGENTS-1:0]   senseQ;
  logic [NUM_AGENTS-1:0]   waitQ;
  logic [NUM_AGENTS-1:0]   relNow;
  logic [NUM_AGENTS-1:0]   accept;
  logic [NUM_AGENTS-1:0]   dupHit;
  logic                    errQ;
  logic [STROBE_CNT_W-1:0] partSum [NUM_AGENTS+1];

  assign partSum[0] = '0;

  for (genvar i = 0; i < NUM_AGENTS; i++) begin : gAgent
    // Released when the global flag catches up with this agent's sense.
    assign relNow[i] = waitQ[i] & (senseQ[i] == flagQ);
    // A new arrival is taken when idle, or in the release cycle itself.
    assign accept[i] = arriveIn[i] & (~waitQ[i] | relNow[i]);
    assign dupHit[i] = arriveIn[i] & waitQ[i] & ~relNow[i];
    assign partSum[i+1] = partSum[i] + {{(STROBE_CNT_W-1){1'b0}}, accept[i]};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        senseQ[i] <= 1'b0;
        waitQ[i]  <= 1'b0;
      end else if (accept[i]) begin
        senseQ[i] <= ~senseQ[i];
        waitQ[i]  <= 1'b1;
      end else if (relNow[i]) begin
        waitQ[i]  <= 1'b0;
      end
    end

    // R7
    release_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
      relNow[i] |=> (!relNow[i] || $past(&accept)));

    // R7
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (waitQ[i] && !relNow[i]) |=> waitQ[i]);

    // R5
    dup_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
      dupHit[i] |=> (senseQ[i] == $past(senseQ[i])));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errQ <= 1'b0;
    else if (|dupHit) errQ <= 1'b1;
  end

  assign strobe.addEn    = |accept;
  assign strobe.addCount = partSum[NUM_AGENTS];
  assign releaseOut      = relNow;
  assign waitingOut      = waitQ;
  assign errorOut        = errQ;

  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errQ |=> errQ);

  // R1
  release_group_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|relNow) |-> (&relNow));

endmodule

// File: rtl/barrier_dpath.sv
module barrier_dpath
  import barrier_pkg::*;
#(
  parameter int NUM_AGENTS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  barStrobe_t strobe,
  output logic       flagQ
);

  localparam int CNT_W = (NUM_AGENTS < 2) ? 1 : $clog2(NUM_AGENTS + 1);
  localparam logic [STROBE_CNT_W-1:0] TARGET = STROBE_CNT_W'(NUM_AGENTS);

  logic [CNT_W-1:0]        countQ;
  logic [STROBE_CNT_W-1:0] nextSum;
  logic                    done;
  logic                    flagR;

  assign nextSum = STROBE_CNT_W'(countQ) + strobe.addCount;
  assign done    = strobe.addEn && (nextSum == TARGET);

  // Counter clear and flag flip share one edge: the next arrival sees zero.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
      flagR  <= 1'b0;
    end else if (done) begin
      countQ <= '0;
      flagR  <= ~flagR;
    end else if (strobe.addEn) begin
      countQ <= CNT_W'(nextSum);
    end
  end

  assign flagQ = flagR;

  // R3
  count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(countQ) < NUM_AGENTS);

  // R2
  no_overshoot_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.addEn |-> (nextSum <= TARGET));

  // R3
  count_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (countQ == '0));

  // R4
  flag_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(flagR) |-> $past(done));

endmodule

// File: rtl/sense_barrier.sv
module sense_barrier
  import barrier_pkg::*;
#(
  parameter int NUM_AGENTS = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_AGENTS-1:0] arriveIn,
  output logic [NUM_AGENTS-1:0] releaseOut,
  output logic [NUM_AGENTS-1:0] waitingOut,
  output logic                  flagOut,
  output logic                  errorOut
);

  barStrobe_t strobe;
  logic       flagQ;

  barrier_ctrl #(.NUM_AGENTS(NUM_AGENTS)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .arriveIn  (arriveIn),
    .flagQ     (flagQ),
    .releaseOut(releaseOut),
    .waitingOut(waitingOut),
    .errorOut  (errorOut),
    .strobe    (strobe)
  );

  barrier_dpath #(.NUM_AGENTS(NUM_AGENTS)) uDpath (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .flagQ (flagQ)
  );

  assign flagOut = flagQ;

endmodule

// File: tb/sim_sense_barrier.sv
module sim_sense_barrier;
  localparam int P = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [P-1:0] arriveIn = '0;
  logic [P-1:0] releaseOut, waitingOut;
  logic         flagOut, errorOut;

  int  testCount = 0;
  int  failCount = 0;
  bit  finished  = 1'b0;
  logic expFlag  = 1'b0;

  always #10 clk = ~clk;

  sense_barrier #(.NUM_AGENTS(P)) u0 (
    .clk(clk), .rstN(rstN), .arriveIn(arriveIn),
    .releaseOut(releaseOut), .waitingOut(waitingOut),
    .flagOut(flagOut), .errorOut(errorOut)
  );

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Strobe a mask for one cycle; returns at the negedge after the sampling edge.
  task automatic pulseArrive(input logic [P-1:0] mask);
    @(negedge clk);
    arriveIn = mask;
    @(negedge clk);
    arriveIn = '0;
  endtask

  task automatic stepIdle();
    @(negedge clk);
    chk("R7", "release after pulse", 8'(releaseOut), 8'h0);
    chk("R7", "waiting after release", 8'(waitingOut), 8'h0);
  endtask

  task automatic testReset();
    chk("R6", "flag", 8'(flagOut), 8'h0);
    chk("R6", "error", 8'(errorOut), 8'h0);
    chk("R6", "waiting", 8'(waitingOut), 8'h0);
    chk("R6", "release", 8'(releaseOut), 8'h0);
  endtask

  task automatic testSerial();
    pulseArrive(4'b0001);
    chk("R1", "wait a0", 8'(waitingOut), 8'h1);
    chk("R1", "no early release", 8'(releaseOut), 8'h0);
    pulseArrive(4'b0010);
    pulseArrive(4'b0100);
    chk("R1", "three of four", 8'(releaseOut), 8'h0);
    chk("R7", "waiting level", 8'(waitingOut), 8'h7);
    pulseArrive(4'b1000);
    expFlag = ~expFlag;
    chk("R1", "group release", 8'(releaseOut), 8'hF);
    chk("R7", "waiting in release cycle", 8'(waitingOut), 8'hF);
    chk("R4", "flag toggled", 8'(flagOut), 8'(expFlag));
    stepIdle();
    chk("R4", "flag stable", 8'(flagOut), 8'(expFlag));
  endtask

  task automatic testSimultaneous();
    pulseArrive(4'b0101);
    chk("R2", "pair counted, no release", 8'(releaseOut), 8'h0);
    chk("R2", "pair waiting", 8'(waitingOut), 8'h5);
    pulseArrive(4'b1010);
    expFlag = ~expFlag;
    chk("R2", "pair completes", 8'(releaseOut), 8'hF);
    chk("R4", "flag back", 8'(flagOut), 8'(expFlag));
    stepIdle();
    pulseArrive(4'b1111);
    expFlag = ~expFlag;
    chk("R2", "all at once", 8'(releaseOut), 8'hF);
    chk("R4", "flag all-at-once", 8'(flagOut), 8'(expFlag));
    stepIdle();
  endtask

  task automatic testBackToBack();
    pulseArrive(4'b0111);
    pulseArrive(4'b1000);
    expFlag = ~expFlag;
    chk("R3", "first episode release", 8'(releaseOut), 8'hF);
    arriveIn = 4'b0011;            // arrive inside the release cycle
    @(negedge clk);
    arriveIn = '0;
    chk("R3", "early arrivals waiting", 8'(waitingOut), 8'h3);
    chk("R3", "no release yet", 8'(releaseOut), 8'h0);
    chk("R3", "not a duplicate", 8'(errorOut), 8'h0);
    pulseArrive(4'b1100);
    expFlag = ~expFlag;
    chk("R3", "second episode from zero", 8'(releaseOut), 8'hF);
    chk("R4", "flag second episode", 8'(flagOut), 8'(expFlag));
    stepIdle();
  endtask

  task automatic testDuplicate();
    pulseArrive(4'b0001);
    pulseArrive(4'b0001);
    chk("R5", "error set", 8'(errorOut), 8'h1);
    chk("R5", "still waiting", 8'(waitingOut), 8'h1);
    pulseArrive(4'b0110);
    chk("R5", "duplicate not counted", 8'(releaseOut), 8'h0);
    chk("R5", "flag unchanged", 8'(flagOut), 8'(expFlag));
    pulseArrive(4'b1000);
    expFlag = ~expFlag;
    chk("R5", "real last arrival releases", 8'(releaseOut), 8'hF);
    stepIdle();
    chk("R5", "error sticky", 8'(errorOut), 8'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSerial();
    testSimultaneous();
    testBackToBack();
    testDuplicate();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule